// File: doc/BRIEF.md
# Windowed Auto-Refresh Scheduler

This block decides when a DDR memory controller must spend a command slot on an auto-refresh. A free-running interval timer adds one owed refresh to a debt counter each time the maximum refresh interval elapses. The block raises a request to the command sequencer while refreshes are owed and the timing rules allow one. The sequencer answers with an acknowledge in the cycle it accepts the request and issues the refresh pair: a write-open command followed at once by the refresh command. All lengths are counted in controller clocks and set by parameters, so the block fits any clock frequency.

Two rules gate the request besides the debt. First, after each accepted refresh, the row-cycle time must pass before the next one. Second, a rate cap applies: any run of `WIN_CNT` consecutive refreshes must span at least `WINDOW_CYC` cycles. With the default settings this means no more than eight refreshes in any 3.2 us window. In distributed mode each owed refresh is requested at once. In burst mode the block lets debt build up to its postponement limit and then drains it back to back, under the gap and window rules. The debt saturates at the limit, where an urgent flag is raised. An acknowledge that arrives with no request raises an error pulse.

Top module: `refresh_sched`

## Requirements
- R1: While `rst_ni` is low, `ref_req_o`, `urgent_o` and `ack_err_o` are 0 and `debt_o` is 0.
- R2: `debt_o` rises by one every `INTERVAL_CYC` cycles. The first rise is visible after the `INTERVAL_CYC`-th rising clock edge following reset release.
- R3: An accepted refresh is a cycle in which both `ref_ack_i` and `ref_req_o` are 1. It lowers `debt_o` by one on the next edge. An interval tick and an accepted refresh in the same cycle leave `debt_o` unchanged.
- R4: `debt_o` never exceeds `DEBT_MAX`. A tick at `DEBT_MAX` with no accepted refresh is dropped. `urgent_o` is 1 exactly when `debt_o` equals `DEBT_MAX`.
- R5: With `burst_mode_i` = 0 (distributed), `ref_req_o` is 1 whenever `debt_o` > 0 and the R6 and R7 rules permit.
- R6: After an accepted refresh, `ref_req_o` stays 0 for the next `TRC_CYC` cycles.
- R7: A refresh may be accepted only if fewer than `WIN_CNT` refreshes were accepted before it, or if the `WIN_CNT`-th most recent accepted refresh lies at least `WINDOW_CYC` cycles in the past.
- R8: With `burst_mode_i` = 1, `ref_req_o` stays 0 until `debt_o` reaches `DEBT_MAX`. From then until `debt_o` returns to 0, requests are made back to back whenever the R6 and R7 rules permit.
- R9: A cycle with `ref_ack_i` = 1 and `ref_req_o` = 0 leaves `debt_o` unchanged and makes `ack_err_o` 1 for exactly the following cycle. `ack_err_o` is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| burst_mode_i | input | 1 | 0 distributed, 1 postpone-and-drain |
| ref_ack_i | input | 1 | Sequencer accepts the refresh pair this cycle |
| ref_req_o | output | 1 | Refresh pair requested |
| debt_o | output | $clog2(DEBT_MAX+1) | Refreshes currently owed |
| urgent_o | output | 1 | Debt at postponement limit |
| ack_err_o | output | 1 | Acknowledge seen without a request in the previous cycle |

## Verification
The interval tick and an accepted refresh can land in the same cycle. In that cycle the debt counter must add and subtract at once and hold its value. The acknowledge is driven randomly over long runs, with a short interval parameter, so these coincidences occur many times and also occur at the saturation limit. A cycle-level bench model keeps its own queue of accept times and applies R3 and R4. The debt it predicts is compared with `debt_o` one cycle later, in every cycle.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;
  typedef enum logic {
    MODE_DIST  = 1'b0,
    MODE_BURST = 1'b1
  } ref_mode_e;
endpackage

// File: rtl/rs_interval_timer.sv
module rs_interval_timer #(
  parameter int INTERVAL_CYC = 1040
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (INTERVAL_CYC > 2) ? $clog2(INTERVAL_CYC) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(INTERVAL_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rs_debt_ctr.sv
module rs_debt_ctr #(
  parameter int DEBT_MAX = 8,
  localparam int DW = $clog2(DEBT_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          take_i,
  output logic [DW-1:0] debt_o,
  output logic          full_o
);
  logic [DW-1:0] debt_q;

  assign full_o = (debt_q == DW'(DEBT_MAX));
  assign debt_o = debt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      debt_q <= '0;
    end else begin
      unique case ({tick_i, take_i})
        2'b10:   if (!full_o) debt_q <= debt_q + 1'b1;
        2'b01:   if (debt_q != '0) debt_q <= debt_q - 1'b1;
        default: debt_q <= debt_q;
      endcase
    end
  end
endmodule

// File: rtl/rs_rate_window.sv
module rs_rate_window #(
  parameter int WIN_CNT    = 8,
  parameter int WINDOW_CYC = 1707,
  parameter int TRC_CYC    = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  output logic open_o
);
  localparam int WW = $clog2(WINDOW_CYC);
  localparam int GW = $clog2(TRC_CYC + 1);
  localparam int PW = $clog2(WIN_CNT);

  logic [GW-1:0]      gap_q;
  logic [PW-1:0]      wptr_q;
  logic [WIN_CNT-1:0] slot_free;

  // row-cycle gap after each accepted refresh
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             gap_q <= '0;
    else if (take_i)         gap_q <= GW'(TRC_CYC);
    else if (gap_q != '0)    gap_q <= gap_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            wptr_q <= '0;
    else if (take_i) begin
      if (wptr_q == PW'(WIN_CNT - 1))       wptr_q <= '0;
      else                                  wptr_q <= wptr_q + 1'b1;
    end
  end

  // one countdown per remembered refresh; slot at wptr is the oldest
  for (genvar i = 0; i < WIN_CNT; i++) begin : g_slot
    logic [WW-1:0] left_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              left_q <= '0;
      else if (take_i && wptr_q == PW'(i))      left_q <= WW'(WINDOW_CYC - 1);
      else if (left_q != '0)                    left_q <= left_q - 1'b1;
    end
    assign slot_free[i] = (left_q == '0);
  end

  assign open_o = (gap_q == '0) && slot_free[wptr_q];
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_sched_pkg::*;
#(
  parameter int INTERVAL_CYC = 1040,
  parameter int WINDOW_CYC   = 1707,
  parameter int WIN_CNT      = 8,
  parameter int TRC_CYC      = 12,
  parameter int DEBT_MAX     = 8,
  localparam int DW = $clog2(DEBT_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          burst_mode_i,
  input  logic          ref_ack_i,
  output logic          ref_req_o,
  output logic [DW-1:0] debt_o,
  output logic          urgent_o,
  output logic          ack_err_o
);
  logic tick, full, open, take, drain_q, err_q, owed, mode_ok;

  rs_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  rs_debt_ctr #(.DEBT_MAX(DEBT_MAX)) u_debt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .take_i(take),
    .debt_o(debt_o),
    .full_o(full)
  );

  rs_rate_window #(
    .WIN_CNT   (WIN_CNT),
    .WINDOW_CYC(WINDOW_CYC),
    .TRC_CYC   (TRC_CYC)
  ) u_window (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .take_i(take),
    .open_o(open)
  );

  // burst mode: drain starts at the cap and runs until debt is cleared
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             drain_q <= 1'b0;
    else if (full)           drain_q <= 1'b1;
    else if (debt_o == '0)   drain_q <= 1'b0;
  end

  assign owed    = (debt_o != '0);
  assign mode_ok = (ref_mode_e'(burst_mode_i) == MODE_DIST) || drain_q || full;

  assign ref_req_o = owed && mode_ok && open;
  assign take      = ref_req_o && ref_ack_i;
  assign urgent_o  = full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= ref_ack_i && !ref_req_o;
  end
  assign ack_err_o = err_q;
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int DEBT_MAX = 8,
  parameter int DW       = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ref_ack_i,
  input logic          ref_req_o,
  input logic [DW-1:0] debt_o,
  input logic          urgent_o,
  input logic          ack_err_o
);
  assert_debt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    debt_o <= DW'(DEBT_MAX));

  assert_urgent_full_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    urgent_o == (debt_o == DW'(DEBT_MAX)));

  assert_req_has_debt_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_req_o |-> debt_o != '0);

  // TRC_CYC is at least 1 by contract
  assert_gap_after_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_req_o && ref_ack_i) |=> !ref_req_o);

  assert_take_lowers_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_req_o && ref_ack_i) |=> debt_o <= $past(debt_o));

  assert_err_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_ack_i && !ref_req_o) |=> ack_err_o);

  assert_no_err_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ref_ack_i && !ref_req_o) |=> !ack_err_o);
endmodule

bind refresh_sched refresh_sched_chk #(
  .DEBT_MAX(DEBT_MAX),
  .DW      (DW)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ref_ack_i(ref_ack_i),
  .ref_req_o(ref_req_o),
  .debt_o   (debt_o),
  .urgent_o (urgent_o),
  .ack_err_o(ack_err_o)
);

// File: tb/refresh_sched_bench.sv
module refresh_sched_bench;
  localparam int CLK_PERIOD = 10;
  localparam int INT_C  = 20;
  localparam int WIN_C  = 100;
  localparam int WCNT   = 8;
  localparam int TRC_C  = 3;
  localparam int DMAX   = 10;
  localparam int DW     = $clog2(DMAX + 1);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic burst_mode_i = 1'b0;
  logic ref_ack_i = 1'b0;
  logic ref_req_o, urgent_o, ack_err_o;
  logic [DW-1:0] debt_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refresh_sched #(
    .INTERVAL_CYC(INT_C),
    .WINDOW_CYC  (WIN_C),
    .WIN_CNT     (WCNT),
    .TRC_CYC     (TRC_C),
    .DEBT_MAX    (DMAX)
  ) u_refresh_sched (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .burst_mode_i(burst_mode_i),
    .ref_ack_i   (ref_ack_i),
    .ref_req_o   (ref_req_o),
    .debt_o      (debt_o),
    .urgent_o    (urgent_o),
    .ack_err_o   (ack_err_o)
  );

  // reference model state
  int  m_cyc = 0;
  int  m_debt = 0;
  int  m_last = -1000;
  bit  m_drain = 1'b0;
  bit  m_err = 1'b0;
  bit  m_prev_tick = 1'b0;
  int  m_hist[$];
  int  coincide = 0;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", tag, m_cyc, act, exp);
    end
  endtask

  function automatic bit gap_ok();
    return (m_cyc - m_last) > TRC_C;
  endfunction

  function automatic bit win_ok();
    return (m_hist.size() < WCNT) || ((m_cyc - m_hist[0]) >= WIN_C);
  endfunction

  function automatic bit exp_req(input bit mode);
    return (m_debt != 0) && (!mode || m_drain || m_debt == DMAX) && gap_ok() && win_ok();
  endfunction

  // called at a negedge; ends at the next negedge
  task automatic step(input bit mode, input int ack_pct, input int spur_pct);
    bit er, ack, tick, acc;
    int nd;
    burst_mode_i = mode;
    #1;
    er = exp_req(mode);
    check(mode ? "R8" : "R5", int'(ref_req_o), int'(er));
    check(m_prev_tick ? "R2" : "R3", int'(debt_o), m_debt);
    check("R4", int'(urgent_o), int'(m_debt == DMAX));
    check("R9", int'(ack_err_o), int'(m_err));
    if (ref_req_o) begin
      check("R6", int'(gap_ok()), 1);
      check("R7", int'(win_ok()), 1);
    end
    if (er) ack = ($urandom % 100) < ack_pct;
    else    ack = ($urandom % 100) < spur_pct;
    ref_ack_i = ack;
    tick = (m_cyc % INT_C) == INT_C - 1;
    acc  = ack && er;
    nd = m_debt;
    if (tick && !acc)      nd = (m_debt < DMAX) ? m_debt + 1 : DMAX;
    else if (!tick && acc) nd = m_debt - 1;
    if (tick && acc) coincide++;  // R3 coincidence case
    if (m_debt == DMAX)  m_drain = 1'b1;
    else if (m_debt == 0) m_drain = 1'b0;
    if (acc) begin
      m_last = m_cyc;
      m_hist.push_back(m_cyc);
      if (m_hist.size() > WCNT) void'(m_hist.pop_front());
    end
    m_err = ack && !er;
    m_prev_tick = tick && !acc;
    m_debt = nd;
    @(posedge clk);
    m_cyc++;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", int'(ref_req_o), 0);
    check("R1", int'(debt_o), 0);
    check("R1", int'(urgent_o), 0);
    check("R1", int'(ack_err_o), 0);
    rst_ni = 1'b1;
    // R2 first tick lands after INT_C edges, no acks
    for (int i = 0; i < INT_C + 2; i++) step(1'b0, 0, 0);
    check("R2", int'(debt_o) >= 1, 1);
    for (int i = 0; i < 300; i++)  step(1'b0, 100, 0);
    for (int i = 0; i < 250; i++)  step(1'b0, 0, 0);   // saturate, R4
    check("R4", int'(urgent_o), 1);
    for (int i = 0; i < 400; i++)  step(1'b1, 100, 0); // drain hits window, R7
    for (int i = 0; i < 1500; i++) step(1'b1, 60, 10);
    for (int i = 0; i < 3000; i++) begin
      bit md;
      md = ((i / 50) % 2) == 1;
      step(md, 50, 15);
    end
    for (int i = 0; i < 400; i++)  step(1'b0, 100, 20);
    check("R3", int'(coincide > 0), 1);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule